// File: doc/BRIEF.md
# DC-Balanced Pixel Frame Serializer

This block turns one parallel pixel per frame period into a 28-bit serial frame, sent one bit per tick of the fast clock. A frame begins with a fixed 1 and ends with a fixed 0. Together these two bits form an embedded clock edge that a receiver can lock onto. Between them sit the 24 payload bits, split into two halves. A control bit and a balance flag sit between the two halves.

The block keeps a running count of ones minus zeros over the payload it has sent. For each new word it decides whether to send the word as it is or inverted, so that this count stays near zero. The balance flag tells the receiver which choice was made. The control bit carries the three video sync signals, one per frame in a fixed rotation, so the receiver can rebuild all three. When the valid strobe is low, the block sends a blank frame so that framing never stops.

The source drives a word, its sync signals and the valid strobe, and holds them steady. The block samples them on the clock edge that ends the last slot of the current frame. It sends them in the frame that follows. `frame_start` marks the first slot of every frame, so the source can pace itself from it.

Top module: `pix_serializer`

## Requirements
- R1: While `rst_n` is low, `ser_out` and `frame_start` are 0. The first rising clock edge after reset is released starts a frame, so `frame_start` is 1 in the cycle that follows.
- R2: Every frame lasts exactly 28 cycles. `frame_start` is 1 only in the first cycle (slot 0) of each frame.
- R3: Slot 0 always carries 1 and slot 27 always carries 0.
- R4: Slots 1 to 12 carry payload bits 0 to 11, slot 13 carries the control bit and slot 14 carries the balance flag. Slots 15 to 26 carry payload bits 12 to 23.
- R5: The balance flag is 1 when the payload slots hold the bitwise inverse of the word, and 0 when they hold the word unchanged.
- R6: Define word bias = 2 x (ones in the word) - 24. The word is inverted exactly when the running disparity and the word bias are both nonzero and have the same sign. A bias of zero never causes an inversion.
- R7: The running disparity starts at 0 and adds (ones - zeros) of each payload as sent. Its magnitude never exceeds 24.
- R8: The control bit rotates through three phases, one per frame: VS, then HS, then DE, then back to VS. The first frame after reset uses the VS phase.
- R9: A frame loaded while `pix_valid` is 0 uses an all-zero word (before the inversion decision) and sends DE as 0.
- R10: Inputs are sampled only on the edge that ends slot 27. Changes at any other time in the frame have no effect on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_data | input | 24 | Pixel payload word |
| pix_vs | input | 1 | Vertical sync |
| pix_hs | input | 1 | Horizontal sync |
| pix_de | input | 1 | Data enable |
| pix_valid | input | 1 | Payload valid; when low a blank frame is sent |
| ser_out | output | 1 | Serial frame bit |
| frame_start | output | 1 | High during slot 0 of each frame |

## Verification
Inputs that the source drives during a frame are sampled at the end of its slot 27. They appear in the next frame, which starts one cycle later, with slot k on the output k cycles after that frame's `frame_start`. The bench drives a new word at the falling edge where it sees `frame_start`. It then samples all 28 slots on the next 28 falling edges and compares them with the frame expected from the word it drove one frame earlier. Because each scenario task uses exactly one frame per call, the bench's model of disparity and phase advances in step with the design. The late-change scenario changes the inputs two slots before the sampling edge, which shows that only the final value is used.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;

  typedef enum logic [1:0] {
    PH_VS = 2'd0,
    PH_HS = 2'd1,
    PH_DE = 2'd2
  } ctl_phase_e;

  function automatic ctl_phase_e phase_after(input ctl_phase_e p);
    case (p)
      PH_VS:   return PH_HS;
      PH_HS:   return PH_DE;
      default: return PH_VS;
    endcase
  endfunction

endpackage

// File: rtl/dcbal_tracker.sv
module dcbal_tracker #(
  parameter int DATA_W = 24,
  parameter int DISP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_load,
  input  logic [DATA_W-1:0]        word,
  output logic                     inv,
  output logic signed [DISP_W-1:0] disp,
  output logic [DATA_W-1:0]        tx_word
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  function automatic logic [CNT_W-1:0] ones_in(input logic [DATA_W-1:0] w);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < DATA_W; i++) n = n + CNT_W'(w[i]);
    return n;
  endfunction

  function automatic logic signed [DISP_W-1:0] word_bias(input logic [CNT_W-1:0] n);
    return DISP_W'(2 * int'(n) - DATA_W);
  endfunction

  logic signed [DISP_W-1:0] disp_q;
  logic signed [DISP_W-1:0] bias;
  logic signed [DISP_W-1:0] step;

  always_comb begin
    bias    = word_bias(ones_in(word));
    inv     = ((disp_q > 0) && (bias > 0)) || ((disp_q < 0) && (bias < 0));
    step    = inv ? -bias : bias;
    tx_word = inv ? ~word : word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          disp_q <= '0;
    else if (frame_load) disp_q <= disp_q + step;
  end

  assign disp = disp_q;
endmodule

// File: rtl/ctl_phase.sv
module ctl_phase
  import pix_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_load,
  input  logic       vs,
  input  logic       hs,
  input  logic       de,
  output logic       dca,
  output ctl_phase_e phase
);
  ctl_phase_e phase_q;

  always_comb begin
    case (phase_q)
      PH_VS:   dca = vs;
      PH_HS:   dca = hs;
      default: dca = de;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          phase_q <= PH_VS;
    else if (frame_load) phase_q <= phase_after(phase_q);
  end

  assign phase = phase_q;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              dca,
  input  logic              dcb,
  output logic              frame_load,
  output logic              ser_out,
  output logic              frame_start
);
  localparam int HALF    = DATA_W / 2;
  localparam int FRAME_W = DATA_W + 4;
  localparam int SLOT_W  = $clog2(FRAME_W);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_W - 1);

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [DATA_W-1:0] w, input logic a, input logic b);
    logic [FRAME_W-1:0] f;
    f                       = '0;
    f[0]                    = 1'b1;
    f[HALF:1]               = w[HALF-1:0];
    f[HALF+1]               = a;
    f[HALF+2]               = b;
    f[FRAME_W-2:HALF+3]     = w[DATA_W-1:HALF];
    f[FRAME_W-1]            = 1'b0;
    return f;
  endfunction

  logic [SLOT_W-1:0]  slot_q;
  logic [FRAME_W-1:0] shift_q;

  assign frame_load = (slot_q == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q  <= LAST_SLOT;
      shift_q <= '0;
    end else if (frame_load) begin
      slot_q  <= '0;
      shift_q <= build_frame(tx_word, dca, dcb);
    end else begin
      slot_q  <= slot_q + 1'b1;
      shift_q <= shift_q >> 1;
    end
  end

  assign ser_out     = shift_q[0];
  assign frame_start = rst_n && (slot_q == '0);
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
  import pix_ser_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              pix_vs,
  input  logic              pix_hs,
  input  logic              pix_de,
  input  logic              pix_valid,
  output logic              ser_out,
  output logic              frame_start
);
  logic                     frame_load;
  logic                     inv;
  logic                     dca;
  logic signed [DISP_W-1:0] disp;
  logic [DATA_W-1:0]        payload;
  logic [DATA_W-1:0]        tx_word;
  logic                     de_eff;
  ctl_phase_e               phase;

  assign payload = pix_valid ? pix_data : '0;
  assign de_eff  = pix_valid & pix_de;

  dcbal_tracker #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_bal (
    .clk(clk), .rst_n(rst_n), .frame_load(frame_load), .word(payload),
    .inv(inv), .disp(disp), .tx_word(tx_word)
  );

  ctl_phase u_ctl (
    .clk(clk), .rst_n(rst_n), .frame_load(frame_load),
    .vs(pix_vs), .hs(pix_hs), .de(de_eff), .dca(dca), .phase(phase)
  );

  frame_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .dca(dca), .dcb(inv),
    .frame_load(frame_load), .ser_out(ser_out), .frame_start(frame_start)
  );
endmodule

// File: rtl/pix_serializer_chk.sv
module pix_serializer_chk #(
  parameter int DATA_W = 24,
  parameter int DISP_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ser_out,
  input logic                     frame_start,
  input logic                     frame_load,
  input logic                     inv,
  input logic signed [DISP_W-1:0] disp,
  input logic [1:0]               phase
);
  function automatic int mag(input logic signed [DISP_W-1:0] v);
    return (v < 0) ? -int'(v) : int'(v);
  endfunction

  // R3
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ser_out);
  // R3
  end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |-> !ser_out);
  // R2
  start_follows_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> frame_start);
  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  // R7
  disp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mag(disp) <= DATA_W);
  // R6
  inv_needs_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv |-> (disp != 0));
  // R8
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);
  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> $stable(phase));
endmodule

bind pix_serializer pix_serializer_chk #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_out(ser_out), .frame_start(frame_start),
  .frame_load(frame_load), .inv(inv), .disp(disp), .phase(phase)
);

// File: tb/pix_serializer_tb.sv
module pix_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pix_data = '0;
  logic         pix_vs = 1'b0, pix_hs = 1'b0, pix_de = 1'b0, pix_valid = 1'b0;
  logic         ser_out, frame_start;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // bench model state
  int           md = 0;
  int           mph = 0;
  int           obs_disp = 0;
  logic [W-1:0] e_tx;
  logic         e_dca, e_dcb, e_blank;

  pix_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .pix_vs(pix_vs),
    .pix_hs(pix_hs), .pix_de(pix_de), .pix_valid(pix_valid),
    .ser_out(ser_out), .frame_start(frame_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected frame for the pixel the design samples at the end of the current frame.
  task automatic predict(input logic [W-1:0] d, input bit vs, input bit hs,
                         input bit de, input bit valid);
    logic [W-1:0] x;
    int bias;
    bit flip;
    x    = valid ? d : '0;
    bias = 2 * $countones(x) - W;
    flip = (md > 0 && bias > 0) || (md < 0 && bias < 0);
    e_tx  = flip ? ~x : x;
    e_dcb = flip;
    md    = md + (flip ? -bias : bias);
    e_dca = (mph == 0) ? vs : (mph == 1) ? hs : (de & valid);
    mph   = (mph + 1) % 3;
    e_blank = !valid;
  endtask

  task automatic drive(input logic [W-1:0] d, input bit vs, input bit hs,
                       input bit de, input bit valid);
    pix_data = d; pix_vs = vs; pix_hs = hs; pix_de = de; pix_valid = valid;
  endtask

  // Consumes one frame: checks it against the pending expectation, loads a new pixel.
  task automatic send(input logic [W-1:0] d, input bit vs, input bit hs,
                      input bit de, input bit valid, input bit late,
                      input logic [W-1:0] early_d, input string req);
    logic [27:0] got, fs;
    logic [W-1:0] rx;
    logic [27:0] fs_exp;
    @(negedge clk);
    while (!frame_start) @(negedge clk);
    for (int i = 0; i < 28; i++) begin
      if (i > 0) @(negedge clk);
      got[i] = ser_out;
      fs[i]  = frame_start;
      if (i == 0) drive(late ? early_d : d, vs, hs, de, valid);
      if (i == 26 && late) drive(d, vs, hs, de, valid);
    end
    for (int j = 0; j < W; j++) rx[j] = (j < 12) ? got[1 + j] : got[3 + j];
    fs_exp = 28'h1;
    check(fs == fs_exp, "R2", "frame_start pattern", 32'(fs), 32'(fs_exp));
    check(got[0] == 1'b1 && got[27] == 1'b0, "R3", "clock slots",
          {30'd0, got[27], got[0]}, 32'd1);
    check(rx == e_tx, req, "payload slots (R4 R5)", 32'(rx), 32'(e_tx));
    check(got[13] == e_dca, "R8", "control slot", 32'(got[13]), 32'(e_dca));
    check(got[14] == e_dcb, "R6", "balance flag", 32'(got[14]), 32'(e_dcb));
    obs_disp = obs_disp + 2 * $countones(rx) - W;
    check(obs_disp <= W && obs_disp >= -W, "R7", "observed disparity bound",
          32'(obs_disp), 32'(W));
    if (e_blank)
      check((rx ^ {W{got[14]}}) == '0, "R9", "blank payload", 32'(rx), 32'(0));
    predict(d, vs, hs, de, valid);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    // R1
    check(ser_out == 1'b0 && frame_start == 1'b0, "R1", "outputs in reset",
          {30'd0, frame_start, ser_out}, 32'd0);
    predict('0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(frame_start == 1'b1, "R1", "first frame start", 32'(frame_start), 32'd1);
  endtask

  task automatic t_blank;
    send(24'hABCDEF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R9");
    send(24'h123456, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R9");
    send(24'hFFFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R9");
  endtask

  task automatic t_bias;
    // all-ones words alternate with inversions once disparity is positive (R6 R7)
    for (int k = 0; k < 4; k++)
      send(24'hFFFFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R6");
    send(24'h000001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R5");
    send(24'h000003, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R5");
  endtask

  task automatic t_tie;
    // twelve ones: zero bias never inverts (R6)
    send(24'h000FFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R6");
    send(24'hFFF000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R6");
  endtask

  task automatic t_patterns;
    send(24'hA5A5A5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R4");
    send(24'h123456, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R4");
    send(24'hFF00FF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R4");
    send(24'h800001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R4");
    send(24'h7FFFFE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R4");
  endtask

  task automatic t_ctl;
    // R8: distinct sync values so each phase picks a different bit
    send(24'h0F0F0F, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, "R8");
    send(24'h0F0F0F, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R8");
    send(24'h0F0F0F, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R8");
    send(24'h0F0F0F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0, "R8");
    send(24'h0F0F0F, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R8");
    send(24'h0F0F0F, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R8");
  endtask

  task automatic t_late;
    // R10: early value is overwritten two slots before sampling
    send(24'h00FF00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 24'hFFFFFF, "R10");
    send(24'hC3C3C3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 24'h000000, "R10");
    send(24'h000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R10");
  endtask

  initial begin
    t_reset;
    t_blank;
    t_bias;
    t_tie;
    t_patterns;
    t_ctl;
    t_late;
    send(24'h000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule